// File: doc/BRIEF.md
# Direct-Mapped Four-Word-Line Data Cache

This block is a read/write data cache placed between a processor port and a word-wide main memory port. It is direct-mapped. Each line carries one valid bit, a tag and four 32-bit words. The line count is set by the `INDEX_W` parameter. The default of 8 gives 256 lines. Setting `INDEX_W` to 12 gives 4096 lines, 64 KB of data and a 16-bit tag. A read that hits returns the addressed word in the same cycle, with no stall. A read that misses holds the processor in a stall while the whole line is fetched from memory one word at a time, then completes from the refilled line.

Stores are write-through. Every store goes to memory, and the processor stalls until memory accepts it. A store that hits also updates the cached word, so the cache never holds data newer than memory. A store that misses does not allocate a line.

The controller has two states. In `ST_LOOKUP` it decodes the request, and a read miss takes the transition *miss-start* into `ST_REFILL`. In `ST_REFILL` it fetches the four words of the line. When memory accepts the fourth word it takes the transition *fill-done* back to `ST_LOOKUP`, and the held read then hits. Stores and hits never leave `ST_LOOKUP`. The state is cleared to `ST_LOOKUP` by a synchronous reset, which also clears every valid bit.

Top module: `dm_line_cache`

## Requirements
- R1: Address fields are split as follows. Bits 1..0 are the byte offset and are ignored. Bits 3..2 select the word within the line. Bits INDEX_W+3..4 are the index. The bits above the index are the tag. A read hit drives the selected word on `cpu_rdata` with `cpu_stall` low in the cycle the request is presented.
- R2: A read hits only when the indexed line is valid and its stored tag equals the address tag. A read to a valid line holding another tag misses, and that line is replaced.
- R3: A synchronous reset clears all valid bits and returns the controller to `ST_LOOKUP`. With no request, `cpu_stall` and `mem_req` are low. The first read of any address after reset misses.
- R4: A read miss raises `cpu_stall`. It then issues four memory reads to word addresses {addr[31:4], 2'b00} through {addr[31:4], 2'b11}, in ascending order. A word transfers on a cycle with `mem_req` and `mem_ready` both high. While `mem_ready` is low, `mem_addr` is held.
- R5: In the cycle after the fourth refill word is accepted, `cpu_stall` is low and `cpu_rdata` holds the requested word. The other three words of the line then hit.
- R6: Every store drives `mem_req` and `mem_we` high, with `mem_addr` = addr[31:2] and `mem_wdata` = `cpu_wdata`. `cpu_stall` equals the inverse of `mem_ready` while the store is pending. Exactly one memory write occurs per store.
- R7: A store that hits updates the cached word. A later read of that word hits and returns the stored value.
- R8: A store that misses does not allocate a line. A later read of that address misses and refills.
- R9: A read hit issues no memory request.
- R10: Lines with different index bits coexist. Two addresses that share the index but differ in tag evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor access request, held stable while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when request is high and stall is low |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Memory transfer request (valid) |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, sampled when request and ready are high |
| mem_ready | input | 1 | Memory accepts or supplies the word this cycle |

## Verification
Directed loads walk all four word offsets of a freshly filled line. This separates a broken word-select mux from a broken refill order. A refill stretched by a stalled memory shows whether the address is held and the cycle count is exact. Conflicting addresses at a shared index, and neighbours at another index, tell a wrong index or tag compare apart from a missing valid check. Store hits, store misses and a mid-run reset each take a separate path. A long random mix of loads and stores, over a footprint larger than the cache and with random memory readiness, is then compared against a shadow tag model and a reference memory.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int WORDS_PER_LINE = 4;
    localparam int WSEL_W         = 2;
    localparam int BYTE_W         = 2;

    typedef enum logic [0:0] {
        ST_LOOKUP = 1'b0,
        ST_REFILL = 1'b1
    } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int INDEX_W = 8,
    parameter int TAG_W   = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INDEX_W-1:0] idx,
    input  logic [TAG_W-1:0]   look_tag,
    input  logic               wr_en,
    output logic               hit
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[idx] <= look_tag;
        end
    end

    assign hit = valid_q[idx] && (tag_q[idx] == look_tag);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int INDEX_W = 8,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic [INDEX_W-1:0]        idx,
    input  logic [dmc_pkg::WSEL_W-1:0] rd_sel,
    output logic [DATA_W-1:0]         rd_word,
    input  logic                      wr_en,
    input  logic [dmc_pkg::WSEL_W-1:0] wr_sel,
    input  logic [DATA_W-1:0]         wr_word
);
    localparam int LINES = 1 << INDEX_W;
    localparam int WORDS = dmc_pkg::WORDS_PER_LINE;

    logic [DATA_W-1:0] lane [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_bank
        logic [DATA_W-1:0] bank_q [LINES];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_sel == dmc_pkg::WSEL_W'(g))) begin
                bank_q[idx] <= wr_word;
            end
        end

        assign lane[g] = bank_q[idx];
    end

    assign rd_word = lane[rd_sel];
endmodule

// File: rtl/dmc_refill_ctrl.sv
module dmc_refill_ctrl
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              hit,
    input  logic              mem_ready,
    output dmc_state_e        state,
    output logic [WSEL_W-1:0] fill_cnt,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic              fill_wr,
    output logic              fill_done,
    output logic              store_wr
);
    dmc_state_e        state_q, state_d;
    logic [WSEL_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOOKUP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_REFILL && mem_ready) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_d   = state_q;
        cpu_stall = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        fill_wr   = 1'b0;
        fill_done = 1'b0;
        store_wr  = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                if (cpu_req && cpu_we) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    cpu_stall = !mem_ready;
                    store_wr  = hit && mem_ready;
                end else if (cpu_req && !hit) begin
                    cpu_stall = 1'b1;
                    state_d   = ST_REFILL;
                end
            end
            ST_REFILL: begin
                mem_req   = 1'b1;
                cpu_stall = 1'b1;
                fill_wr   = mem_ready;
                if (mem_ready && cnt_q == WSEL_W'(WORDS_PER_LINE - 1)) begin
                    fill_done = 1'b1;
                    state_d   = ST_LOOKUP;
                end
            end
            default: state_d = ST_LOOKUP;
        endcase
    end

    assign state    = state_q;
    assign fill_cnt = cnt_q;
endmodule

// File: rtl/dm_line_cache.sv
module dm_line_cache
    import dmc_pkg::*;
#(
    parameter int INDEX_W = 8,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic                     cpu_stall,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-BYTE_W-1:0] mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic [DATA_W-1:0]        mem_rdata,
    input  logic                     mem_ready
);
    localparam int IDX_LO = BYTE_W + WSEL_W;
    localparam int TAG_LO = IDX_LO + INDEX_W;
    localparam int TAG_W  = ADDR_W - TAG_LO;

    logic [TAG_W-1:0]   a_tag;
    logic [INDEX_W-1:0] a_idx;
    logic [WSEL_W-1:0]  a_word;
    logic               byte_ofs_unused;

    assign a_tag           = cpu_addr[ADDR_W-1:TAG_LO];
    assign a_idx           = cpu_addr[TAG_LO-1:IDX_LO];
    assign a_word          = cpu_addr[IDX_LO-1:BYTE_W];
    assign byte_ofs_unused = ^cpu_addr[BYTE_W-1:0];

    dmc_state_e        state;
    logic [WSEL_W-1:0] fill_cnt;
    logic              hit, fill_wr, fill_done, store_wr;

    dmc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .idx      (a_idx),
        .look_tag (a_tag),
        .wr_en    (fill_done),
        .hit      (hit)
    );

    dmc_refill_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .hit       (hit),
        .mem_ready (mem_ready),
        .state     (state),
        .fill_cnt  (fill_cnt),
        .cpu_stall (cpu_stall),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .fill_wr   (fill_wr),
        .fill_done (fill_done),
        .store_wr  (store_wr)
    );

    logic               d_wr_en;
    logic [WSEL_W-1:0]  d_wr_sel;
    logic [DATA_W-1:0]  d_wr_word;

    assign d_wr_en   = fill_wr || store_wr;
    assign d_wr_sel  = fill_wr ? fill_cnt : a_word;
    assign d_wr_word = fill_wr ? mem_rdata : cpu_wdata;

    dmc_data_store #(.INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .idx     (a_idx),
        .rd_sel  (a_word),
        .rd_word (cpu_rdata),
        .wr_en   (d_wr_en),
        .wr_sel  (d_wr_sel),
        .wr_word (d_wr_word)
    );

    assign mem_addr  = (state == ST_REFILL) ? {a_tag, a_idx, fill_cnt}
                                            : cpu_addr[ADDR_W-1:BYTE_W];
    assign mem_wdata = cpu_wdata;
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                cpu_req,
    input logic                cpu_we,
    input logic [ADDR_W-1:0]   cpu_addr,
    input logic [DATA_W-1:0]   cpu_wdata,
    input logic                cpu_stall,
    input logic                mem_req,
    input logic                mem_we,
    input logic [ADDR_W-3:0]   mem_addr,
    input logic [DATA_W-1:0]   mem_wdata,
    input logic                mem_ready
);
    // R9
    a_r9_hit_quiet: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_we && !cpu_stall) |-> !mem_req);

    // R6
    a_r6_store_fwd: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (cpu_req && cpu_we && mem_addr == cpu_addr[ADDR_W-1:2]
                                 && mem_wdata == cpu_wdata));

    a_r6_store_stall: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we) |-> (cpu_stall == !mem_ready));

    // R4
    a_r4_fill_line: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (cpu_stall && mem_addr[ADDR_W-3:2] == cpu_addr[ADDR_W-1:4]));

    a_r4_fill_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && !mem_ready) |=> (mem_req && !mem_we && $stable(mem_addr)));

    a_r4_fill_step: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ready && mem_addr[1:0] != 2'd3)
        |=> (mem_req && !mem_we && mem_addr[1:0] == $past(mem_addr[1:0]) + 2'd1));

    // R5
    a_r5_fill_done: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ready && mem_addr[1:0] == 2'd3) |=> !cpu_stall);

    // R3
    a_r3_cold_miss: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && cpu_req && !cpu_we) |-> cpu_stall);
endmodule

bind dm_line_cache dmc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_stall (cpu_stall),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/dm_line_cache_tb.sv
`timescale 1ns/1ps
module dm_line_cache_tb;
    localparam int IW = 4;
    localparam int LN = 1 << IW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall, mem_req, mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mem_ready = 1'b1;

    always #4 clk = ~clk;

    dm_line_cache #(.INDEX_W(IW)) u_dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    logic [31:0] bmem [1024];
    logic [31:0] ref_mem [1024];
    bit          sh_valid [LN];
    logic [23:0] sh_tag [LN];

    int    checks = 0, errors = 0;
    int    rd_cnt = 0, wr_cnt = 0;
    int    fill_k = 0;
    logic [27:0] fill_line = '0;
    logic [31:0] cur_addr = '0, cur_wd = '0;
    bit    rand_ready = 1'b0;
    bit    done = 1'b0;

    assign mem_rdata = bmem[mem_addr[9:0]];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] init_word(input int i);
        return (i * 32'h9E3779B1) ^ (32'h5A5A0000 + i);
    endfunction

    function automatic bit exp_hit(input logic [31:0] a);
        return sh_valid[a[7:4]] && sh_tag[a[7:4]] == a[31:8];
    endfunction

    // memory responder and traffic monitor
    always @(posedge clk) begin
        if (!rst && mem_req && mem_ready) begin
            if (mem_we) begin
                wr_cnt++;
                chk(mem_addr == cur_addr[31:2], "R6", "store address", {2'b0, mem_addr}, {2'b0, cur_addr[31:2]});
                chk(mem_wdata == cur_wd, "R6", "store data", mem_wdata, cur_wd);
                bmem[mem_addr[9:0]] <= mem_wdata;
            end else begin
                rd_cnt++;
                chk(mem_addr == {fill_line, 2'(fill_k)}, "R4", "refill order",
                    {2'b0, mem_addr}, {2'b0, fill_line, 2'(fill_k)});
                fill_k = (fill_k + 1) % 4;
            end
        end
    end

    function automatic logic pick_ready(input int cyc, input int hold);
        if (cyc < hold) return 1'b0;
        if (rand_ready) return 1'($urandom % 2);
        return 1'b1;
    endfunction

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                          input int hold, output logic [31:0] rd, output int nrd,
                          output int nwr, output bit st0, output int cycs, output bit held);
        int cyc;
        logic [29:0] a0;
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; fill_k = 0;
        fill_line = a[31:4]; cur_addr = a; cur_wd = wd;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        cyc = 0; held = 1'b1;
        mem_ready = pick_ready(cyc, hold);
        #1;
        st0 = cpu_stall;
        a0 = mem_addr;
        while (cpu_stall && cyc < 300) begin
            @(negedge clk);
            cyc++;
            mem_ready = pick_ready(cyc, hold);
            #1;
            if (cyc < hold && mem_addr != a0) held = 1'b0;
        end
        if (cyc >= 300) chk(1'b0, "R4", "access timeout", 32'(cyc), 32'd0);
        rd = cpu_rdata;
        cycs = cyc;
        @(posedge clk);
        #1;
        nrd = rd_cnt; nwr = wr_cnt;
        cpu_req = 1'b0;
    endtask

    // reads and stores with shadow-model expectations
    task automatic do_read(input logic [31:0] a, input int hold, input string req);
        logic [31:0] rd; int nrd, nwr, cy; bit s0, hd, h;
        h = exp_hit(a);
        access(1'b0, a, 32'h0, hold, rd, nrd, nwr, s0, cy, hd);
        chk(rd == ref_mem[a[11:2]], req, "load data", rd, ref_mem[a[11:2]]);
        chk(nrd == (h ? 0 : 4), h ? "R9" : "R4", "memory reads", 32'(nrd), h ? 32'd0 : 32'd4);
        chk(s0 == !h, h ? "R1" : "R2", "first-cycle stall", 32'(s0), 32'(!h));
        sh_valid[a[7:4]] = 1'b1;
        sh_tag[a[7:4]] = a[31:8];
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] wd, input int hold);
        logic [31:0] rd; int nrd, nwr, cy; bit s0, hd;
        access(1'b1, a, wd, hold, rd, nrd, nwr, s0, cy, hd);
        chk(nwr == 1 && nrd == 0, "R6", "one store transfer", 32'(nwr), 32'd1);
        ref_mem[a[11:2]] = wd;
    endtask

    initial begin
        int seed;
        logic [31:0] rd; int nrd, nwr, cy; bit s0, hd;
        seed = $urandom(32'h00C0FFEE);
        for (int i = 0; i < 1024; i++) begin
            bmem[i] = init_word(i);
            ref_mem[i] = init_word(i);
        end
        for (int i = 0; i < LN; i++) sh_valid[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(cpu_stall == 1'b0 && mem_req == 1'b0, "R3", "idle after reset",
            {30'b0, cpu_stall, mem_req}, 32'd0);

        // R3 cold miss, R4 refill, R5 completion
        do_read(32'h0000_0040, 0, "R5");
        // R1 word select across the line, byte offset ignored
        do_read(32'h0000_0045, 0, "R1");
        do_read(32'h0000_004A, 0, "R1");
        do_read(32'h0000_004F, 0, "R1");

        // R4 stretched refill with memory not ready
        access(1'b0, 32'h0000_0100, 32'h0, 3, rd, nrd, nwr, s0, cy, hd);
        chk(cy == 7, "R4", "refill cycles with 3 wait cycles", 32'(cy), 32'd7);
        chk(hd, "R4", "address held while not ready", 32'(hd), 32'd1);
        chk(rd == ref_mem[10'h040], "R5", "stretched refill data", rd, ref_mem[10'h040]);
        sh_valid[0] = 1'b1; sh_tag[0] = 24'h000001;

        // R2 / R10 conflict at index 4, coexistence at index 5
        do_read(32'h0000_0448, 0, "R2");
        do_read(32'h0000_0040, 0, "R10");
        do_read(32'h0000_0050, 0, "R10");
        do_read(32'h0000_0044, 0, "R10");

        // R6 store with memory wait, R7 store hit visible
        access(1'b1, 32'h0000_0044, 32'hDEAD_BEEF, 2, rd, nrd, nwr, s0, cy, hd);
        chk(cy == 2 && s0 == 1'b1, "R6", "store stall length", 32'(cy), 32'd2);
        chk(nwr == 1, "R6", "single memory write", 32'(nwr), 32'd1);
        ref_mem[10'h011] = 32'hDEAD_BEEF;
        do_read(32'h0000_0044, 0, "R7");

        // R8 store miss does not allocate
        do_write(32'h0000_0808, 32'h1234_5678, 0);
        do_read(32'h0000_0808, 0, "R8");

        // R3 reset mid-run invalidates lines
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < LN; i++) sh_valid[i] = 1'b0;
        do_read(32'h0000_0808, 0, "R3");

        // random mix with random memory readiness
        rand_ready = 1'b1;
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a;
            a = {22'b0, 8'($urandom % 96), 2'($urandom % 4)};
            if ($urandom % 3 == 0) do_write(a, $urandom, 0);
            else do_read(a, 0, "R2");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule